// File: doc/BRIEF.md
# Memory-Mapped 64-bit Timer with One-Shot Alarm

A free-running 64-bit time counter with a one-shot compare alarm and a level interrupt, reached through a simple 32-bit register port decoded inside a 4 KiB window. The counter starts at zero on reset. It advances by a parameterised increment once every parameterised number of clock cycles. With the defaults it counts one unit per clock, which is a nanosecond base at 1 GHz.

Software reads time as two words. Reading the low word also latches the upper half of the same counter value, so the following high-word read gives a consistent 64-bit value. An alarm is set by writing the upper word first and then the lower word. The lower-word write arms the compare. When the counter reaches or passes the alarm, a sticky pending flag sets and the alarm disarms. The interrupt line is the pending flag gated by an enable bit. A write to a clear register drops the pending flag.

Register word offsets: 0x00 time low, 0x04 time high snapshot, 0x08 alarm low (arms), 0x0C alarm high, 0x10 interrupt enable (bit 0), 0x14 alarm cancel (bit 0), 0x18 interrupt clear (bit 0).

Top module: `tat_top`

## Requirements
- R1: After reset the counter, snapshot, alarm, armed state, pending flag and enable bit are all zero, `irq_o` is low and `rdata_o` is zero.
- R2: The counter advances by TICK_INC on every TICK_DIV-th rising clock edge after reset release, and holds its value between those edges.
- R3: A read at 0x00 returns bits 31:0 of the counter as held just before the access edge. In the same access it latches bits 63:32 of that value into the snapshot.
- R4: A read at 0x04 returns the snapshot from the latest 0x00 read, not the live upper counter bits.
- R5: A write at 0x0C stores the upper alarm word. A write at 0x08 loads the alarm with {stored upper word, written data} and arms it. Reads at 0x08 and 0x0C return the alarm low word and the stored upper word.
- R6: One edge after the alarm is armed with the counter greater than or equal to the alarm value, the pending flag sets and the alarm disarms.
- R7: One-shot: after firing, no further event occurs until 0x08 is written again. A write at 0x14 with bit 0 set disarms a pending-free armed alarm so that it never fires.
- R8: Bit 0 of 0x10 is the interrupt enable. `irq_o` equals pending AND enable, and the pending flag survives any toggling of the enable.
- R9: A write at 0x18 with bit 0 set clears the pending flag. The same write with bit 0 clear has no effect.
- R10: Reads of undefined offsets return zero, writes to them change nothing, and address bits 1:0 are ignored. Read data appears on `rdata_o` one edge after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the 4 KiB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt: pending AND enable |

## Verification
The bench builds the block with TICK_DIV = 2 and TICK_INC = 0x1000_0000. The divider then produces idle edges between ticks, which tests the hold behaviour of R2. The large step carries the counter across the 32-bit boundary every 32 clocks. The snapshot, the high-word alarm compare and the split alarm write are therefore exercised with non-zero upper words in a short run. The bench also places alarms in the past and in the future, and it cancels an armed alarm before its time.

// File: rtl/tat_pkg.sv
package tat_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = ADDR_W - 2;

  typedef enum logic [WORD_W-1:0] {
    REG_TIME_LO   = 10'd0,
    REG_TIME_HI   = 10'd1,
    REG_ALARM_LO  = 10'd2,
    REG_ALARM_HI  = 10'd3,
    REG_IRQ_EN    = 10'd4,
    REG_ALARM_CLR = 10'd5,
    REG_IRQ_CLR   = 10'd6
  } reg_word_e;

  typedef struct packed {
    logic rd_time_lo;
    logic wr_alarm_lo;
    logic wr_alarm_hi;
    logic wr_irq_en;
    logic wr_alarm_clr;
    logic wr_irq_clr;
  } strobe_t;
endpackage

// File: rtl/tat_prescaler.sv
module tat_prescaler #(
  parameter int unsigned TICK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every_cycle
      logic unused_clk_rst;
      assign unused_clk_rst = clk_i ^ rst_ni;
      assign tick_o = 1'b1;
    end else begin : g_divider
      localparam int unsigned DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                        div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DIV_LAST);

      // two ticks never land on consecutive edges when dividing
      assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tat_counter.sv
module tat_counter #(
  parameter int unsigned HALF_W   = 32,
  parameter int unsigned TICK_INC = 1,
  localparam int unsigned CNT_W   = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              snap_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [HALF_W-1:0] snap_hi_o
);
  localparam logic [CNT_W-1:0] INC_EXT = CNT_W'(TICK_INC);

  logic [CNT_W-1:0]  count_q;
  logic [HALF_W-1:0] snap_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (tick_i) count_q <= count_q + INC_EXT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_hi_q <= '0;
    else if (snap_i) snap_hi_q <= count_q[CNT_W-1:HALF_W];
  end

  assign count_o   = count_q;
  assign snap_hi_o = snap_hi_q;

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> count_q == $past(count_q) + INC_EXT);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_q));
  assert_snap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> snap_hi_q == $past(count_q[CNT_W-1:HALF_W]));
endmodule

// File: rtl/tat_alarm.sv
module tat_alarm
  import tat_pkg::*;
#(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  strobe_t           strb_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  alarm_o,
  output logic [HALF_W-1:0] alarm_hi_o,
  output logic              irq_en_o,
  output logic              irq_o
);
  logic [HALF_W-1:0] alarm_hi_q;
  logic [CNT_W-1:0]  alarm_q;
  logic              armed_q, pending_q, irq_en_q;
  logic              hit;

  assign hit = armed_q && (count_i >= alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_hi_q <= '0;
      alarm_q    <= '0;
      irq_en_q   <= 1'b0;
    end else begin
      if (strb_i.wr_alarm_hi) alarm_hi_q <= wdata_i;
      if (strb_i.wr_alarm_lo) alarm_q    <= {alarm_hi_q, wdata_i};
      if (strb_i.wr_irq_en)   irq_en_q   <= wdata_i[0];
    end
  end

  // arming write wins over a same-cycle hit or cancel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 armed_q <= 1'b0;
    else if (strb_i.wr_alarm_lo)                 armed_q <= 1'b1;
    else if (hit)                                armed_q <= 1'b0;
    else if (strb_i.wr_alarm_clr && wdata_i[0])  armed_q <= 1'b0;
  end

  // a hit wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               pending_q <= 1'b0;
    else if (hit)                              pending_q <= 1'b1;
    else if (strb_i.wr_irq_clr && wdata_i[0])  pending_q <= 1'b0;
  end

  assign alarm_o    = alarm_q;
  assign alarm_hi_o = alarm_hi_q;
  assign irq_en_o   = irq_en_q;
  assign irq_o      = pending_q & irq_en_q;

  assert_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && (count_i >= alarm_q) && !strb_i.wr_alarm_lo |=> pending_q && !armed_q);
  assert_oneshot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_q) |-> !armed_q || $past(strb_i.wr_alarm_lo));
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q && !(strb_i.wr_irq_clr && wdata_i[0]) |=> pending_q);
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.wr_irq_clr && wdata_i[0] && !armed_q |=> !pending_q);
endmodule

// File: rtl/tat_regif.sv
module tat_regif
  import tat_pkg::*;
#(
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] snap_hi_i,
  input  logic [CNT_W-1:0]  alarm_i,
  input  logic [DATA_W-1:0] alarm_hi_i,
  input  logic              irq_en_i,
  output strobe_t           strb_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [WORD_W-1:0] word;
  logic              wr, rd;
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic              unused_addr_lsb;

  assign word            = addr_i[ADDR_W-1:2];
  assign unused_addr_lsb = ^addr_i[1:0];
  assign wr              = req_i & we_i;
  assign rd              = req_i & ~we_i;

  always_comb begin
    strb_o              = '0;
    strb_o.rd_time_lo   = rd && (word == REG_TIME_LO);
    strb_o.wr_alarm_lo  = wr && (word == REG_ALARM_LO);
    strb_o.wr_alarm_hi  = wr && (word == REG_ALARM_HI);
    strb_o.wr_irq_en    = wr && (word == REG_IRQ_EN);
    strb_o.wr_alarm_clr = wr && (word == REG_ALARM_CLR);
    strb_o.wr_irq_clr   = wr && (word == REG_IRQ_CLR);
  end

  always_comb begin
    case (word)
      REG_TIME_LO:  rd_val = count_i[DATA_W-1:0];
      REG_TIME_HI:  rd_val = snap_hi_i;
      REG_ALARM_LO: rd_val = alarm_i[DATA_W-1:0];
      REG_ALARM_HI: rd_val = alarm_hi_i;
      REG_IRQ_EN:   rd_val = {{(DATA_W-1){1'b0}}, irq_en_i};
      default:      rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(strb_o) <= 1);
endmodule

// File: rtl/tat_top.sv
module tat_top
  import tat_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1,
  parameter int unsigned TICK_INC = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic              tick;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] snap_hi;
  logic [CNT_W-1:0]  alarm;
  logic [DATA_W-1:0] alarm_hi;
  logic              irq_en;
  strobe_t           strb;

  tat_prescaler #(.TICK_DIV(TICK_DIV)) i_prescaler (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  tat_counter #(.HALF_W(DATA_W), .TICK_INC(TICK_INC)) i_counter (
    .clk_i, .rst_ni, .tick_i(tick), .snap_i(strb.rd_time_lo),
    .count_o(count), .snap_hi_o(snap_hi)
  );

  tat_alarm #(.HALF_W(DATA_W)) i_alarm (
    .clk_i, .rst_ni, .count_i(count), .strb_i(strb), .wdata_i(wdata_i),
    .alarm_o(alarm), .alarm_hi_o(alarm_hi), .irq_en_o(irq_en), .irq_o(irq_o)
  );

  tat_regif i_regif (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .count_i(count), .snap_hi_i(snap_hi), .alarm_i(alarm),
    .alarm_hi_i(alarm_hi), .irq_en_i(irq_en),
    .strb_o(strb), .rdata_o(rdata_o)
  );

  assert_irq_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.wr_irq_en && !wdata_i[0] |=> !irq_o);
endmodule

// File: tb/test_tat_top.sv
module test_tat_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned TB_DIV = 2;
  localparam int unsigned TB_INC = 32'h1000_0000;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tat_top #(.TICK_DIV(TB_DIV), .TICK_INC(TB_INC)) i_tat_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model built from the requirements
  int unsigned div_m;
  logic [63:0] cnt_m, alarm_m;
  logic [31:0] ahi_m, snap_m;
  logic        armed_m, pend_m, en_m, rd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_m <= 0; cnt_m <= '0; alarm_m <= '0; ahi_m <= '0;
      armed_m <= 1'b0; pend_m <= 1'b0; en_m <= 1'b0; rd_seen <= 1'b0;
    end else begin
      rd_seen <= req && !we;
      if (div_m == TB_DIV - 1) begin
        div_m <= 0;
        cnt_m <= cnt_m + 64'(TB_INC);
      end else div_m <= div_m + 1;
      if (req && we && addr[11:2] == 10'd6 && wdata[0]) pend_m <= 1'b0;
      if (req && we && addr[11:2] == 10'd5 && wdata[0]) armed_m <= 1'b0;
      if (armed_m && cnt_m >= alarm_m) begin
        pend_m <= 1'b1;
        armed_m <= 1'b0;
      end
      if (req && we) begin
        case (addr[11:2])
          10'd2: begin alarm_m <= {ahi_m, wdata}; armed_m <= 1'b1; end
          10'd3: ahi_m <= wdata;
          10'd4: en_m <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_irq(input string tag);
    check(irq === (pend_m & en_m), tag, 64'(irq), 64'(pend_m & en_m));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_seen) begin
      if (sb_q.size() == 0) check(1'b0, "scoreboard underflow", 0, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rdata === e.exp, e.tag, 64'(rdata), 64'(e.exp));
      end
    end
  end

  // driver: a==0/4 compute time expectations at the access
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_t item;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    item.tag = tag;
    if (a[11:2] == 10'd0) begin
      item.exp = cnt_m[31:0];
      snap_m = cnt_m[63:32];
    end else if (a[11:2] == 10'd1) item.exp = snap_m;
    else item.exp = e;
    sb_q.push_back(item);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [63:0] tgt;
    logic [31:0] held;
    snap_m = '0;
    idle(3);
    check(irq === 1'b0, "R1 irq in reset", 64'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata === 32'h0 && irq === 1'b0, "R1 outputs after reset",
          {rdata, 31'b0, irq}, 0);
    rd(12'h004, 0, "R1 snapshot zero");
    rd(12'h008, 0, "R1 alarm low zero");
    rd(12'h00C, 0, "R1 alarm high zero");
    rd(12'h010, 0, "R1 enable zero");

    // R2/R3 reads at both divider phases
    rd(12'h000, 0, "R3 time low a");
    idle(1);
    rd(12'h000, 0, "R3 time low b");
    rd(12'h004, 0, "R4 snapshot after low read");
    idle(40);
    rd(12'h000, 0, "R2 R3 time low after carry");
    check(snap_m != 0, "R2 counter carried into upper word", 64'(snap_m), 1);
    idle(70);
    rd(12'h004, 0, "R4 snapshot not live");
    check(cnt_m[63:32] != snap_m, "R4 live upper bits moved on",
          64'(cnt_m[63:32]), 64'(snap_m));
    rd(12'h000, 0, "R3 time low refresh");
    rd(12'h004, 0, "R4 snapshot refreshed");

    // R10 address handling
    rd(12'h01C, 0, "R10 unused offset");
    rd(12'hFFC, 0, "R10 top of window");
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h013, 0, "R10 undefined write no effect enable, lsb ignored");
    rd(12'h00C, 0, "R10 undefined write no effect alarm");
    held = rdata;
    idle(5);
    check(rdata === held, "R10 read data held", 64'(rdata), 64'(held));

    // R5/R6 future alarm
    wr(12'h010, 32'h1);
    rd(12'h010, 1, "R8 enable readback");
    tgt = cnt_m + 64'(30) * 64'(TB_INC);
    wr(12'h00C, tgt[63:32]);
    wr(12'h008, tgt[31:0]);
    rd(12'h00C, tgt[63:32], "R5 alarm high readback");
    rd(12'h008, tgt[31:0], "R5 alarm low readback");
    check(irq === 1'b0, "R6 no early fire", 64'(irq), 0);
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      check_irq("R6 irq tracks alarm");
    end
    check(irq === 1'b1, "R6 alarm fired", 64'(irq), 1);

    // R8 enable toggling keeps pending
    wr(12'h010, 32'h0);
    check(irq === 1'b0, "R8 disabled masks", 64'(irq), 0);
    idle(4);
    wr(12'h010, 32'h1);
    check(irq === 1'b1, "R8 pending survives toggle", 64'(irq), 1);

    // R9 clear
    wr(12'h018, 32'h0);
    check(irq === 1'b1, "R9 clear with bit0=0 ignored", 64'(irq), 1);
    wr(12'h018, 32'h1);
    check(irq === 1'b0, "R9 clear drops irq", 64'(irq), 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(irq === 1'b0, "R7 one-shot no refire", 64'(irq), 0);
    end

    // R6 past alarm: fires one edge after arming
    wr(12'h00C, 32'h0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'h008; wdata = 32'h0;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check(irq === 1'b0, "R6 arm edge no irq yet", 64'(irq), 0);
    @(negedge clk);
    check(irq === 1'b1, "R6 past alarm fires next edge", 64'(irq), 1);
    wr(12'h018, 32'h1);
    check_irq("R9 clear after past alarm");

    // R7 cancel
    tgt = cnt_m + 64'(20) * 64'(TB_INC);
    wr(12'h00C, tgt[63:32]);
    wr(12'h008, tgt[31:0]);
    wr(12'h014, 32'h1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check(irq === 1'b0, "R7 cancelled alarm silent", 64'(irq), 0);
    end

    // R8 fire while disabled, then enable
    wr(12'h010, 32'h0);
    tgt = cnt_m + 64'(5) * 64'(TB_INC);
    wr(12'h00C, tgt[63:32]);
    wr(12'h008, tgt[31:0]);
    idle(20);
    check(irq === 1'b0, "R8 masked while disabled", 64'(irq), 0);
    wr(12'h010, 32'h1);
    check(irq === 1'b1, "R8 enable exposes pending", 64'(irq), 1);
    check_irq("R8 model agreement");

    idle(2);
    check(sb_q.size() == 0, "scoreboard drained", 64'(sb_q.size()), 0);
    finish_run();
  end
endmodule